// File: doc/BRIEF.md
# Port Command and Status Register

This block holds one port's command and status word for a serial storage host controller. Software reaches it over a plain 32-bit register bus. A write strobe carries the data into it, and a read strobe returns the stored word. Part of the word belongs to software. The rest is owned by hardware and ignores software writes: those bits are merged through a fixed protection mask before each write is committed.

Two engine-enable bits come from software. One enables command-list fetch and one enables received-frame storage. Each engine has a base address, and the block checks that base for a legal region before it lets the engine run. With a legal base, the running flag of that engine rises in the same commit. When the enable bit is written low, the running flag is cleared explicitly. When an engine is enabled over an illegal base, it is not started and a one-cycle error pulse is produced.

The top four bits form a link power request field, and the block decodes the two low-power request codes from it.

Top module: `port_cmd_status`

## Requirements
- R1: On a write, every bit outside the protection mask 0x007DFFE0 takes the written value.
- R2: On a write, every bit inside the mask other than bits 15 and 14 keeps its stored value. After reset, such a bit always reads 0.
- R3: A write with bit 0 (start) set, while the command-list base is legal, sets bit 15 (command-list running) and the `clbRunning` output from the next cycle. A base is legal when it is nonzero and a multiple of CL_BYTES (default 1024).
- R4: A write with bit 0 clear clears bit 15 and `clbRunning`.
- R5: A write with bit 4 (frame-receive enable) set, while the frame base is legal, sets bit 14 and `fisRunning`. A frame base is legal when it is nonzero and a multiple of FIS_BYTES (default 256). A write with bit 4 clear clears bit 14.
- R6: When an engine is enabled over an illegal base, its running bit keeps its previous value. In that case `mapErr` is high for exactly the one cycle after the write, and a failing write raises it once, even when both engines fail.
- R7: Bits 15 and 14 can never be set by the written data itself. Writing 1 to them with the matching enable bit clear leaves them 0.
- R8: `partialReq` is high while bits 31:28 hold 0x2, and `slumberReq` is high while they hold 0x6.
- R9: Reset clears the whole word, both running flags and `mapErr`.
- R10: `rdData` shows the stored word while `rdEn` is high and is 0 otherwise.
- R11: Without a write, the stored word does not change, even when either base address changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, zero when not reading |
| clbBase | input | ADDR_W | Command-list region base address |
| fisBase | input | ADDR_W | Frame-receive region base address |
| clbRunning | output | 1 | Command-list engine running |
| fisRunning | output | 1 | Frame-receive engine running |
| mapErr | output | 1 | One-cycle pulse for a write that enabled an engine over an illegal base |
| partialReq | output | 1 | Power field requests the partial state |
| slumberReq | output | 1 | Power field requests the slumber state |

## Verification
Random full-word writes are paired with base addresses drawn from three kinds: legal, zero and misaligned. This separates the cases where the mask merge acts alone from those where the engine bits override it, and a started engine from a refused one. Directed sequences cover several cases:
- start and stop of each engine;
- repeated failing writes back to back, where the error pulse must repeat but never stretch;
- writes with both enables failing, which must still give a single pulse;
- idle cycles with changing bases, which must leave the word untouched.

The two power codes are written explicitly, next to neighbouring codes that must decode to neither request.

// File: rtl/port_cmd_pkg.sv
package port_cmd_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] RO_MASK = 32'h007D_FFE0;
  localparam int START_BIT = 0;
  localparam int FRE_BIT = 4;
  localparam int CLR_BIT = 15;
  localparam int FRR_BIT = 14;
  localparam int PWR_LSB = 28;
  localparam int PWR_W = 4;
  localparam logic [PWR_W-1:0] PWR_PARTIAL = 4'h2;
  localparam logic [PWR_W-1:0] PWR_SLUMBER = 4'h6;
  localparam logic [REG_W-1:0] RUN_MASK = (REG_W'(1) << CLR_BIT) | (REG_W'(1) << FRR_BIT);
  localparam logic [REG_W-1:0] RO_FIXED = RO_MASK & ~RUN_MASK;

  typedef struct packed {
    logic commit;
    logic clbSet;
    logic clbClr;
    logic fisSet;
    logic fisClr;
    logic mapFail;
  } cmdStrobe_t;
endpackage

// File: rtl/region_addr_chk.sv
module region_addr_chk #(
  parameter int ADDR_W = 32,
  parameter int REGION_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] base,
  output logic              ok
);
  localparam bool_pow2 = ((REGION_BYTES & (REGION_BYTES - 1)) == 0);
  localparam int ALIGN_W = (REGION_BYTES > 1) ? $clog2(REGION_BYTES) : 1;

  generate
    if (bool_pow2 && REGION_BYTES > 1) begin : g_pow2
      always_comb ok = (base != '0) && (base[ALIGN_W-1:0] == '0);
    end else begin : g_mod
      always_comb ok = (base != '0) && ((base % ADDR_W'(REGION_BYTES)) == '0);
    end
  endgenerate
endmodule

// File: rtl/port_cmd_ctrl.sv
module port_cmd_ctrl
  import port_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             clbOk,
  input  logic             fisOk,
  output cmdStrobe_t       stb
);
  logic startReq;
  logic freReq;

  always_comb begin
    startReq    = wrData[START_BIT];
    freReq      = wrData[FRE_BIT];
    stb.commit  = wrEn;
    stb.clbSet  = wrEn && startReq && clbOk;
    stb.clbClr  = wrEn && !startReq;
    stb.fisSet  = wrEn && freReq && fisOk;
    stb.fisClr  = wrEn && !freReq;
    stb.mapFail = wrEn && ((startReq && !clbOk) || (freReq && !fisOk));
  end

  // R6
  fail_only_on_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.mapFail |-> (stb.commit && !(stb.clbSet && stb.fisSet)));

  // R4
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.clbSet && stb.clbClr) && !(stb.fisSet && stb.fisClr));
endmodule

// File: rtl/port_cmd_dp.sv
module port_cmd_dp
  import port_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobe_t       stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] cmdQ,
  output logic             errQ
);
  logic [REG_W-1:0] cmdNext;

  always_comb begin
    cmdNext = (cmdQ & RO_MASK) | (wrData & ~RO_MASK);
    if (stb.clbSet)      cmdNext[CLR_BIT] = 1'b1;
    else if (stb.clbClr) cmdNext[CLR_BIT] = 1'b0;
    if (stb.fisSet)      cmdNext[FRR_BIT] = 1'b1;
    else if (stb.fisClr) cmdNext[FRR_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (stb.commit) cmdQ <= cmdNext;
      errQ <= stb.mapFail;
    end
  end

  // R1
  rw_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> ((cmdQ & ~RO_MASK) == ($past(wrData) & ~RO_MASK)));

  // R2
  ro_fixed_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ & RO_FIXED) == '0);

  // R4
  clb_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !wrData[START_BIT]) |=> !cmdQ[CLR_BIT]);

  // R7
  run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !wrData[START_BIT] && !wrData[FRE_BIT]) |=> ((cmdQ & RUN_MASK) == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(cmdQ));

  // R6
  err_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(stb.commit));
endmodule

// File: rtl/port_cmd_status.sv
module port_cmd_status
  import port_cmd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CL_BYTES = 1024,
  parameter int FIS_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  input  logic [ADDR_W-1:0] clbBase,
  input  logic [ADDR_W-1:0] fisBase,
  output logic              clbRunning,
  output logic              fisRunning,
  output logic              mapErr,
  output logic              partialReq,
  output logic              slumberReq
);
  logic             clbOk;
  logic             fisOk;
  cmdStrobe_t       stb;
  logic [REG_W-1:0] cmdQ;
  logic [PWR_W-1:0] pwrField;

  region_addr_chk #(.ADDR_W(ADDR_W), .REGION_BYTES(CL_BYTES)) uClbChk (
    .base(clbBase), .ok(clbOk));

  region_addr_chk #(.ADDR_W(ADDR_W), .REGION_BYTES(FIS_BYTES)) uFisChk (
    .base(fisBase), .ok(fisOk));

  port_cmd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .clbOk(clbOk), .fisOk(fisOk), .stb(stb));

  port_cmd_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cmdQ(cmdQ), .errQ(mapErr));

  always_comb begin
    pwrField   = cmdQ[PWR_LSB +: PWR_W];
    rdData     = rdEn ? cmdQ : '0;
    clbRunning = cmdQ[CLR_BIT];
    fisRunning = cmdQ[FRR_BIT];
    partialReq = (pwrField == PWR_PARTIAL);
    slumberReq = (pwrField == PWR_SLUMBER);
  end

  // R3
  clb_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[START_BIT] && clbOk) |=> clbRunning);

  // R5
  fis_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[FRE_BIT] && fisOk) |=> fisRunning);

  // R8
  pwr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(partialReq && slumberReq));
endmodule

// File: tb/port_cmd_status_test.sv
`timescale 1ns/1ps
module port_cmd_status_test;
  localparam logic [31:0] MASK = 32'h007D_FFE0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic rdEn = 1'b1;
  logic [31:0] rdData;
  logic [31:0] clbBase = '0;
  logic [31:0] fisBase = '0;
  logic clbRunning, fisRunning, mapErr, partialReq, slumberReq;

  int checks = 0;
  int fails = 0;
  logic [31:0] model = '0;
  logic modelErr = 1'b0;

  always #2 clk = ~clk;

  port_cmd_status uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .clbBase(clbBase), .fisBase(fisBase),
    .clbRunning(clbRunning), .fisRunning(fisRunning), .mapErr(mapErr),
    .partialReq(partialReq), .slumberReq(slumberReq));

  function automatic logic legal(input logic [31:0] a, input int unsigned sz);
    return (a != 0) && (a % sz == 0);
  endfunction

  function automatic logic [32:0] predict(input logic [31:0] cur, input logic [31:0] wd,
                                           input logic [31:0] cb, input logic [31:0] fb);
    logic [31:0] m;
    logic e;
    m = (cur & MASK) | (wd & ~MASK);
    e = 1'b0;
    if (wd[0]) begin
      if (legal(cb, 1024)) m[15] = 1'b1; else e = 1'b1;
    end else m[15] = 1'b0;
    if (wd[4]) begin
      if (legal(fb, 256)) m[14] = 1'b1; else e = 1'b1;
    end else m[14] = 1'b0;
    return {e, m};
  endfunction

  function automatic logic [31:0] pickBase(input int unsigned sz);
    int unsigned k;
    k = $urandom_range(0, 3);
    if (k == 0) return 32'h0;
    if (k == 1) return ($urandom() & ~(sz - 1)) | sz | 32'h3;
    return ($urandom() & ~(sz - 1)) | sz;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " rdData"}, rdData, model);
    chk({req, " clbRunning"}, 32'(clbRunning), 32'(model[15]));
    chk({req, " fisRunning"}, 32'(fisRunning), 32'(model[14]));
    chk({req, " mapErr"}, 32'(mapErr), 32'(modelErr));
    chk({req, " partialReq"}, 32'(partialReq), 32'(model[31:28] == 4'h2));
    chk({req, " slumberReq"}, 32'(slumberReq), 32'(model[31:28] == 4'h6));
  endtask

  task automatic doWrite(input logic [31:0] wd, input logic [31:0] cb,
                         input logic [31:0] fb, input string req);
    logic [32:0] p;
    p = predict(model, wd, cb, fb);
    wrEn = 1'b1; wrData = wd; clbBase = cb; fisBase = fb;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    model = p[31:0];
    modelErr = p[32];
    checkAll(req);
  endtask

  task automatic idle(input string req);
    @(posedge clk);
    @(negedge clk);
    modelErr = 1'b0;
    checkAll(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    checkAll("R9 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R9 after reset");

    // R10 read strobe low gives zero
    doWrite(32'h6000_0000, 32'h0, 32'h0, "R8 slumber code");
    rdEn = 1'b0;
    #0.1;
    chk("R10 rdEn low", rdData, 32'h0);
    rdEn = 1'b1;

    // R8 power codes and neighbours
    doWrite(32'h2000_0000, 32'h0, 32'h0, "R8 partial code");
    doWrite(32'h3000_0000, 32'h0, 32'h0, "R8 neighbour code");
    doWrite(32'h7000_0000, 32'h0, 32'h0, "R8 neighbour code 7");

    // R3 and R5 start both engines
    doWrite(32'h0000_0011, 32'h0001_0000, 32'h0002_0100, "R3 R5 start");
    // R11 idle with base changes
    clbBase = 32'h0; fisBase = 32'h5;
    idle("R11 idle base change");
    // R6 failing start keeps running bit, pulse then drop
    doWrite(32'h0000_0011, 32'h0000_0400, 32'h0000_0003, "R6 fis fail keep");
    idle("R6 pulse drops");
    // R4 stop command engine, R5 stop receive
    doWrite(32'h0000_0010, 32'h0000_0400, 32'h0000_0100, "R4 stop clb");
    doWrite(32'h0000_0000, 32'h0000_0400, 32'h0000_0100, "R5 stop fis");
    // R7 direct write to running bits
    doWrite(32'h0000_C000, 32'h0000_0400, 32'h0000_0100, "R7 direct set");
    // R2 write ones everywhere with illegal bases: both fail, one pulse (R6)
    doWrite(32'hFFFF_FFFF, 32'h0, 32'h0, "R2 R6 all ones");
    doWrite(32'hFFFF_FFFF, 32'h0000_0200, 32'h0000_0080, "R6 repeat fail");
    idle("R6 single pulse");
    // R1 random merge
    for (int i = 0; i < 400; i++) begin
      logic [31:0] cb;
      logic [31:0] fb;
      logic [31:0] wd;
      cb = pickBase(1024);
      fb = pickBase(256);
      wd = $urandom();
      if ($urandom_range(0, 3) == 0) wd[31:28] = ($urandom_range(0, 1) == 0) ? 4'h2 : 4'h6;
      doWrite(wd, cb, fb, "R1 random");
      if ($urandom_range(0, 4) == 0) begin
        clbBase = $urandom(); fisBase = $urandom();
        idle("R11 random idle");
      end
    end
    // R9 reset again after activity
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    model = '0; modelErr = 1'b0;
    checkAll("R9 mid reset");
    rstN = 1'b1;

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule